// File: doc/BRIEF.md
# Quadrature Oscillator with Shift-Add Rotator

This block is a numerically controlled oscillator that produces a cosine and a sine word together, one pair per clock. Each valid input adds a phase step to a wrapping phase register whose full range stands for one turn. The phase then drives a chain of rotation stages built only from shifts and adders. The chain returns the amplitude input scaled by the cosine and the sine of that phase.

A small fixed-coefficient pre-scale by the inverse of the rotation gain is applied to the start vector, so the outputs need no correction afterwards. The top two phase bits choose whether the start vector is negated, which leaves the rotation chain with residual angles inside one half turn. The caller supplies a new step and amplitude on any clock with the valid input high. The results come out a fixed number of cycles later, flagged by the output valid.

Top module: `nco_cordic_top`

## Requirements
- R1: A synchronous reset clears the phase register and every pipeline stage. On the clock after a reset cycle `out_vld` is 0, and `sin_out` and `cos_out` stay 0 until the first valid result comes out.
- R2: `out_vld` equals `in_vld` delayed by exactly DATA_W+1 clocks (15 with defaults), and valid inputs on back-to-back clocks give valid outputs on back-to-back clocks.
- R3: The phase register starts at 0 after reset. On each clock with `in_vld` high it adds `phase_inc` modulo 2^PHASE_W, and the result of that clock uses the updated value. The phase is unsigned, and 2^PHASE_W units equal 2π radians.
- R4: `cos_out` is within 4 LSB of amp·cos(2π·phase/2^PHASE_W), with `amp` unsigned and the output signed two's complement.
- R5: `sin_out` is within 4 LSB of amp·sin(2π·phase/2^PHASE_W).
- R6: R4 and R5 also hold at the exact quarter-turn points (phase 0, 2^(PHASE_W-2), 2^(PHASE_W-1), 3·2^(PHASE_W-2)) and in all four quadrants.
- R7: A clock with `in_vld` low neither advances the phase nor takes in `amp`. The next valid input continues from the phase reached before the gap.
- R8: Amplitude 0 gives zero outputs. No output ever equals the most negative code -2^(DATA_W-1), and sin²+cos² never exceeds (2^(DATA_W-1)+4)².
- R9: A step of 2^PHASE_W−k acts as a negative step of k, because the phase register wraps with no special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Step and amplitude are valid this clock |
| phase_inc | input | PHASE_W | Unsigned phase step, full scale equals one turn |
| amp | input | DATA_W-1 | Unsigned output amplitude |
| out_vld | output | 1 | Output pair is valid |
| sin_out | output | DATA_W | Signed amp·sin(phase) |
| cos_out | output | DATA_W | Signed amp·cos(phase) |

## Verification
Every result is due DATA_W+1 clocks after the step that produced it: one clock for the phase register and one for each of the DATA_W rotation stages. The bench records what it drives in each cycle, indexed by cycle number. At each falling edge it compares the outputs with the record from exactly DATA_W+1 cycles earlier. A reset erases the records still in flight, so the bench expects the outputs to go quiet at once. Value checks use a real-valued model fed by the bench's own copy of the phase accumulation.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W_DEF = 20;
    localparam int DATA_W_DEF  = 14;
    localparam int GUARD_DEF   = 3;

    // Inverse rotation gain 1/K ~ 0.607253 in unsigned Q0.16
    localparam int                    GAIN_FRAC  = 16;
    localparam logic [GAIN_FRAC-1:0]  INV_GAIN_Q = 16'd39797;

    // Arctangent of 2^-idx in units where 2^32 is one full turn.
    // Beyond the listed entries atan(x) ~ x is accurate to well below 1 unit.
    function automatic logic [31:0] atan_turn32(input int idx);
        logic [31:0] t;
        case (idx)
            0:  t = 32'h20000000;
            1:  t = 32'h12E4051E;
            2:  t = 32'h09FB385B;
            3:  t = 32'h051111D4;
            4:  t = 32'h028B0D43;
            5:  t = 32'h0145D7E1;
            6:  t = 32'h00A2F61E;
            7:  t = 32'h00517C55;
            8:  t = 32'h0028BE53;
            9:  t = 32'h00145F2F;
            10: t = 32'h000A2F98;
            11: t = 32'h000517CC;
            12: t = 32'h00028BE6;
            13: t = 32'h000145F3;
            14: t = 32'h0000A2F9;
            15: t = 32'h0000517D;
            default: t = 32'(64'd683565276 >> idx);
        endcase
        return t;
    endfunction

    // Same angle rescaled to a pw-bit turn, rounded (pw must be below 32)
    function automatic longint unsigned atan_units(input int idx, input int pw);
        longint unsigned w;
        w = 64'(atan_turn32(idx));
        return (w + (64'd1 << (31 - pw))) >> (32 - pw);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PW = 20,
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [PW-1:0] step,
    input  logic [AW-1:0] amp,
    output logic          vld_q,
    output logic [PW-1:0] phase_q,
    output logic [AW-1:0] amp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            phase_q <= '0;
            amp_q   <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                phase_q <= phase_q + step;   // wraps naturally: full scale is one turn
                amp_q   <= amp;
            end
        end
    end
endmodule

// File: rtl/nco_prerot.sv
module nco_prerot
    import nco_pkg::*;
#(
    parameter int PW = 20,
    parameter int AW = 13,
    parameter int IW = 19,
    parameter int G  = 3
) (
    input  logic [PW-1:0]        phase,
    input  logic [AW-1:0]        amp,
    output logic signed [IW-1:0] x0,
    output logic signed [IW-1:0] y0,
    output logic signed [PW-1:0] z0
);
    localparam int SH     = GAIN_FRAC - G;
    localparam int PROD_W = AW + GAIN_FRAC;
    localparam logic [PROD_W-1:0] RND = PROD_W'(1) << (SH - 1);

    logic [PROD_W-1:0]        prod;
    logic [PROD_W-1:0]        mag;
    logic signed [IW-1:0]     mag_s;
    logic                     half_turn;

    always_comb begin
        prod      = PROD_W'(amp) * PROD_W'(INV_GAIN_Q);
        mag       = (prod + RND) >> SH;
        mag_s     = IW'(mag);
        // Phase in the second or third quadrant: start from the negated vector
        half_turn = phase[PW-1] ^ phase[PW-2];
        x0        = half_turn ? -mag_s : mag_s;
        y0        = '0;
        // Residual angle after the optional half turn, in [-quarter, +quarter)
        z0        = $signed({phase[PW-2], phase[PW-2:0]});
    end
endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
    parameter int             IW    = 19,
    parameter int             PW    = 20,
    parameter int             SHIFT = 0,
    parameter logic [PW-1:0]  ANGLE = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [PW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [PW-1:0] z_o
);
    logic signed [IW-1:0] x_sh;
    logic signed [IW-1:0] y_sh;
    logic                 turn_pos;

    always_comb begin
        x_sh     = x_i >>> SHIFT;
        y_sh     = y_i >>> SHIFT;
        turn_pos = ~z_i[PW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            x_o   <= '0;
            y_o   <= '0;
            z_o   <= '0;
        end else begin
            vld_o <= vld_i;
            if (turn_pos) begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
                z_o <= z_i - $signed(ANGLE);
            end else begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
                z_o <= z_i + $signed(ANGLE);
            end
        end
    end
endmodule

// File: rtl/nco_cordic_top.sv
module nco_cordic_top
    import nco_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int GUARD   = GUARD_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic [PHASE_W-1:0]       phase_inc,
    input  logic [DATA_W-2:0]        amp,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] sin_out,
    output logic signed [DATA_W-1:0] cos_out
);
    localparam int STAGES = DATA_W;
    localparam int AW     = DATA_W - 1;
    localparam int IW     = DATA_W + GUARD + 2;

    localparam logic signed [IW-1:0] HALF = IW'(1 << (GUARD - 1));
    localparam logic signed [IW-1:0] LIM  = IW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [IW-1:0] NLIM = -LIM;

    logic               acc_vld;
    logic [PHASE_W-1:0] acc_phase;
    logic [AW-1:0]      acc_amp;

    logic                      v_pipe [0:STAGES];
    logic signed [IW-1:0]      x_pipe [0:STAGES];
    logic signed [IW-1:0]      y_pipe [0:STAGES];
    logic signed [PHASE_W-1:0] z_pipe [0:STAGES-1];
    logic signed [PHASE_W-1:0] z_resid_unused;

    nco_phase_acc #(.PW(PHASE_W), .AW(AW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .step    (phase_inc),
        .amp     (amp),
        .vld_q   (acc_vld),
        .phase_q (acc_phase),
        .amp_q   (acc_amp)
    );

    nco_prerot #(.PW(PHASE_W), .AW(AW), .IW(IW), .G(GUARD)) u_pre (
        .phase (acc_phase),
        .amp   (acc_amp),
        .x0    (x_pipe[0]),
        .y0    (y_pipe[0]),
        .z0    (z_pipe[0])
    );

    assign v_pipe[0] = acc_vld;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam logic [PHASE_W-1:0] ANG = PHASE_W'(atan_units(i, PHASE_W));
        if (i < STAGES - 1) begin : g_mid
            nco_cordic_stage #(.IW(IW), .PW(PHASE_W), .SHIFT(i), .ANGLE(ANG)) u_stg (
                .clk (clk), .rst (rst),
                .vld_i (v_pipe[i]), .x_i (x_pipe[i]), .y_i (y_pipe[i]), .z_i (z_pipe[i]),
                .vld_o (v_pipe[i+1]), .x_o (x_pipe[i+1]), .y_o (y_pipe[i+1]), .z_o (z_pipe[i+1])
            );
        end else begin : g_last
            nco_cordic_stage #(.IW(IW), .PW(PHASE_W), .SHIFT(i), .ANGLE(ANG)) u_stg (
                .clk (clk), .rst (rst),
                .vld_i (v_pipe[i]), .x_i (x_pipe[i]), .y_i (y_pipe[i]), .z_i (z_pipe[i]),
                .vld_o (v_pipe[i+1]), .x_o (x_pipe[i+1]), .y_o (y_pipe[i+1]), .z_o (z_resid_unused)
            );
        end
    end

    // Drop guard bits with rounding and clamp to the symmetric output range
    function automatic logic signed [DATA_W-1:0] to_out(input logic signed [IW-1:0] v);
        logic signed [IW-1:0] r;
        r = (v + HALF) >>> GUARD;
        if (r > LIM)       r = LIM;
        else if (r < NLIM) r = NLIM;
        return r[DATA_W-1:0];
    endfunction

    always_comb begin
        out_vld = v_pipe[STAGES];
        cos_out = to_out(x_pipe[STAGES]);
        sin_out = to_out(y_pipe[STAGES]);
    end
endmodule

// File: rtl/nco_cordic_chk.sv
module nco_cordic_chk #(
    parameter int DATA_W = 14
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_vld,
    input logic                     out_vld,
    input logic signed [DATA_W-1:0] sin_out,
    input logic signed [DATA_W-1:0] cos_out
);
    localparam int LAT  = DATA_W + 1;
    localparam int SQ_W = 2 * DATA_W + 2;
    localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [SQ_W-1:0] RAD2 =
        SQ_W'(((1 << (DATA_W - 1)) + 4) * ((1 << (DATA_W - 1)) + 4));

    logic [LAT-1:0]         vhist;
    logic                   seen;
    logic signed [SQ_W-1:0] se;
    logic signed [SQ_W-1:0] ce;
    logic [SQ_W-1:0]        rad;

    always_ff @(posedge clk) begin
        if (rst) begin
            vhist <= '0;
            seen  <= 1'b0;
        end else begin
            vhist <= {vhist[LAT-2:0], in_vld};
            if (out_vld) seen <= 1'b1;
        end
    end

    always_comb begin
        se  = SQ_W'(sin_out);
        ce  = SQ_W'(cos_out);
        rad = $unsigned(se * se + ce * ce);
    end

    // R2: output valid is the input valid delayed by the full pipeline
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_vld == vhist[LAT-1]);

    // R1: a reset cycle leaves no valid output behind it
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !out_vld);

    // R1: outputs stay zero until the first valid result after reset
    a_r1_quiet_zero: assert property (@(posedge clk) disable iff (rst)
        (!seen && !out_vld) |-> (sin_out == '0 && cos_out == '0));

    // R8: the most negative code is never produced
    a_r8_no_min_code: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (sin_out != MINV && cos_out != MINV));

    // R8: output vector stays within the full-scale circle
    a_r8_radius: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (rad <= RAD2));
endmodule

bind nco_cordic_top nco_cordic_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .sin_out (sin_out),
    .cos_out (cos_out)
);

// File: tb/nco_cordic_top_tb_top.sv
`timescale 1ns/1ps
module nco_cordic_top_tb_top;
    localparam int  PW     = 20;
    localparam int  DW     = 14;
    localparam int  LAT    = DW + 1;
    localparam int  HMAX   = 1024;
    localparam int  MAXV   = (1 << (DW - 1)) - 1;
    localparam real TOL    = 4.0;
    localparam real TWO_PI = 6.283185307179586;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] inc;
        logic [DW-2:0] amp;
        logic [7:0]    reps;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{1'b1, 20'd0,       13'd8191, 8'd1},
        '{1'b1, 20'd262144,  13'd8191, 8'd4},
        '{1'b1, 20'd12345,   13'd5000, 8'd40},
        '{1'b0, 20'd777,     13'd4000, 8'd6},
        '{1'b1, 20'd12345,   13'd5000, 8'd10},
        '{1'b1, 20'd1040799, 13'd3000, 8'd30},
        '{1'b1, 20'd524288,  13'd8191, 8'd3},
        '{1'b1, 20'd87381,   13'd1,    8'd12},
        '{1'b1, 20'd99999,   13'd0,    8'd5},
        '{1'b1, 20'd1048575, 13'd8191, 8'd4}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_vld = 1'b0;
    logic [PW-1:0]        phase_inc = '0;
    logic [DW-2:0]        amp = '0;
    logic                 out_vld;
    logic signed [DW-1:0] sin_out;
    logic signed [DW-1:0] cos_out;

    always #2 clk = ~clk;

    nco_cordic_top #(.PHASE_W(PW), .DATA_W(DW)) dut_i (
        .clk (clk), .rst (rst), .in_vld (in_vld), .phase_inc (phase_inc),
        .amp (amp), .out_vld (out_vld), .sin_out (sin_out), .cos_out (cos_out)
    );

    int            nchk = 0;
    int            nfail = 0;
    int            cyc = 0;
    bit            done = 1'b0;
    bit            quiet = 1'b1;
    logic [PW-1:0] bacc = '0;
    logic          hv [0:HMAX-1];
    logic [PW-1:0] hp [0:HMAX-1];
    int            ha [0:HMAX-1];
    string         ht [0:HMAX-1];

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input real exp);
        real d;
        nchk++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            nfail++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0.3f", tag, cyc, act, exp);
        end
    endtask

    task automatic chk_le(input string tag, input int act, input int lim);
        nchk++;
        if (act > lim) begin
            nfail++;
            $display("FAIL %s cycle %0d: actual=%0d expected<=%0d", tag, cyc, act, lim);
        end
    endtask

    // Compare outputs with what was driven LAT cycles earlier
    task automatic check_outputs();
        logic exp_v;
        real  ang;
        int   s, c;
        exp_v = (cyc >= LAT) ? hv[cyc-LAT] : 1'b0;
        chk_bit("R2 out_vld", out_vld, exp_v);
        s = int'(sin_out);
        c = int'(cos_out);
        if (exp_v) begin
            quiet = 1'b0;
            ang = TWO_PI * real'(hp[cyc-LAT]) / real'(1 << PW);
            chk_near((ht[cyc-LAT] == "") ? "R5 sin" : {ht[cyc-LAT], " sin"},
                     s, real'(ha[cyc-LAT]) * $sin(ang));
            chk_near((ht[cyc-LAT] == "") ? "R4 cos" : {ht[cyc-LAT], " cos"},
                     c, real'(ha[cyc-LAT]) * $cos(ang));
            chk_le("R8 range", (s < 0 ? -s : s) + (c < 0 ? -c : c) - MAXV, MAXV);
            chk_le("R8 sin bound", (s < 0 ? -s : s), MAXV);
        end else if (quiet) begin
            chk_near("R1 quiet sin", s, 0.0);
            chk_near("R1 quiet cos", c, 0.0);
        end
    endtask

    task automatic step(input logic v, input logic [PW-1:0] i, input logic [DW-2:0] a,
                        input string tag);
        @(negedge clk);
        cyc++;
        check_outputs();
        rst       = 1'b0;
        in_vld    = v;
        phase_inc = i;
        amp       = a;
        hv[cyc]   = v;
        ht[cyc]   = tag;
        if (v) bacc = bacc + i;
        hp[cyc]   = bacc;
        ha[cyc]   = int'(a);
    endtask

    task automatic do_reset(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc++;
            check_outputs();
            rst    = 1'b1;
            in_vld = 1'b0;
            for (int j = cyc - LAT + 1; j <= cyc; j++)
                if (j >= 0) hv[j] = 1'b0;
            bacc  = '0;
            quiet = 1'b1;
        end
        step(1'b0, '0, '0, "");
    endtask

    function automatic string auto_tag(input vec_t e, input logic [PW-1:0] ph, input bit after_gap);
        if (e.amp == '0)                return "R8";
        if (after_gap)                  return "R7";
        if (ph[PW-3:0] == '0)           return "R6";
        if (e.inc[PW-1])                return "R9";
        return "";
    endfunction

    initial begin
        for (int k = 0; k < HMAX; k++) begin
            hv[k] = 1'b0; hp[k] = '0; ha[k] = 0; ht[k] = "";
        end
        do_reset(3);

        // Table walk: back-to-back samples, a gap, negative steps, amplitude extremes
        begin
            bit gap_seen;
            gap_seen = 1'b0;
            for (int e = 0; e < 10; e++) begin
                for (int r = 0; r < int'(VECS[e].reps); r++) begin
                    logic [PW-1:0] nxt;
                    nxt = bacc + VECS[e].inc;
                    if (!VECS[e].vld) begin
                        step(1'b0, VECS[e].inc, VECS[e].amp, "R7");
                        gap_seen = 1'b1;
                    end else begin
                        step(1'b1, VECS[e].inc, VECS[e].amp, auto_tag(VECS[e], nxt, gap_seen));
                        gap_seen = 1'b0;
                    end
                end
            end
        end
        for (int k = 0; k < LAT + 2; k++) step(1'b0, '0, '0, "");

        // Reset while samples are in flight, then phase restarts from 0 (R1, R3)
        for (int k = 0; k < 5; k++) step(1'b1, 20'd30000, 13'd6000, "R3");
        do_reset(2);
        step(1'b1, 20'd262144, 13'd8191, "R3");
        step(1'b1, 20'd262144, 13'd8191, "R3");
        for (int k = 0; k < LAT + 2; k++) step(1'b0, '0, '0, "");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule